// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects a parameterised set of interrupt lines (up to 32) and merges them into one request line for a processor. Every line owns a captured-status bit. That bit is set by a rising transition or by an asserted level, depending on a per-line configuration mask fixed at build time. Software reads and controls the block through eight 32-bit registers on a plain strobe bus. The strobe bus has a write strobe, a read strobe, a byte address, write data and registered read data.

Software unmasks a line through its enable bit and services the request. It finds the line through the vector register and then clears the captured bit through the acknowledge register. Enable bits can be changed by a direct write or by atomic set and clear writes, so one driver never disturbs another driver's bits. Two master bits must both be on before any pending line reaches the processor.

Word select is address bits [4:2]. Address bits [1:0] are ignored. An address with any bit set above bit 4 is unmapped. Register words are: 0 captured status (read-only), 1 pending (read-only), 2 enable, 3 acknowledge (write-only), 4 set-enable (write-only), 5 clear-enable (write-only), 6 vector (read-only), 7 master control.

Top module: `irqc_top`

## Requirements
- R1: An edge-configured line (mask bit 1) sets its status bit on the clock edge where the line is 1 and its previous sample was 0. The previous sample is 0 after reset. The bit then stays set until it is acknowledged, whatever the line does.
- R2: A level-configured line (mask bit 0) sets its status bit on every clock edge where the line is 1. An acknowledge while the line is still 1 leaves the bit set.
- R3: Writing word 3 clears the status bits written as 1 and leaves the other bits alone. A new set event in the same cycle wins over the clear.
- R4: Writing word 2 loads the enable bits directly. Writing 0 there masks every line and leaves the status bits unchanged.
- R5: Writing word 4 ORs the data into the enable bits. Writing word 5 clears the enable bits written as 1. Enable bits not written as 1 keep their value.
- R6: Word 1 reads as status AND enable.
- R7: Word 7 holds the master enable in bit 0 and the hardware enable in bit 1, and both bits read back. The request output is 1 exactly when some pending bit is 1 and both master bits are 1. It follows the registered state with no further delay.
- R8: Word 6 reads the index of the lowest-numbered pending line, zero-extended. It reads 0xFFFFFFFF when no line is pending.
- R9: Read data appears on the clock edge after the read strobe and holds until the next read. Words 3, 4 and 5 read as 0. Unmapped addresses read as 0 and ignore writes. Writes to words 0, 1 and 6 change nothing.
- R10: Register bits at positions at or above the line count read as 0, and writes to them are ignored.
- R11: After reset all status, enable and master bits are 0, the request output is 0 and the vector reads 0xFFFFFFFF. The asynchronous reset is released synchronously through two flops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| irq_lines_i | input | N_IN | Interrupt lines, synchronous to clk |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Registered read data |
| irq_o | output | 1 | Request to the processor |

## Verification
Faults in the status or enable bits show up at the request pin on the very next clock. They also show up in the status, pending and vector reads one cycle after the read strobe. A lost edge, a bit that clears too early, or a bad priority choice therefore shows within one or two cycles at the ports. The bench runs a cycle-exact reference model next to the design, so any mismatch in request level or read data is caught on the cycle it appears.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [2:0] {
    REG_STAT   = 3'd0,
    REG_PEND   = 3'd1,
    REG_EN     = 3'd2,
    REG_ACK    = 3'd3,
    REG_SETEN  = 3'd4,
    REG_CLREN  = 3'd5,
    REG_VEC    = 3'd6,
    REG_MASTER = 3'd7
  } reg_sel_e;
endpackage

// File: rtl/irqc_rst_sync.sv
module irqc_rst_sync (
  input  logic clk,
  input  logic arst_n_i,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge arst_n_i) begin
    if (!arst_n_i) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/irqc_capture.sv
module irqc_capture #(
  parameter int            N_IN     = 32,
  parameter logic [31:0]   EDGE_CFG = 32'h0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_IN-1:0] line_i,
  input  logic [N_IN-1:0] ack_i,
  output logic [N_IN-1:0] status_o
);
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] status_q;
  logic [N_IN-1:0] status_d;
  logic [N_IN-1:0] set_evt;
  logic            status_ce;
  logic            prev_ce;

  for (genvar i = 0; i < N_IN; i++) begin : g_sense
    if (EDGE_CFG[i]) begin : g_edge
      assign set_evt[i] = line_i[i] & ~prev_q[i];
    end else begin : g_level
      assign set_evt[i] = line_i[i];
      AST_LEVEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        line_i[i] |=> status_q[i]); // R2
    end
  end

  always_comb begin
    status_d  = (status_q & ~ack_i) | set_evt;
    status_ce = (status_d != status_q);
    prev_ce   = (prev_q != line_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      prev_q   <= '0;
    end else begin
      if (status_ce) status_q <= status_d;
      if (prev_ce)   prev_q   <= line_i;
    end
  end

  assign status_o = status_q;

  AST_STATUS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(status_q & ~ack_i)) == $past(status_q & ~ack_i))); // R1
endmodule

// File: rtl/irqc_prio.sv
module irqc_prio #(
  parameter int N_IN  = 32,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  pend_i,
  output logic [IDX_W-1:0] idx_o,
  output logic             any_o
);
  always_comb begin
    idx_o = '0;
    any_o = 1'b0;
    for (int i = N_IN - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        idx_o = IDX_W'(i);
        any_o = 1'b1;
      end
    end
  end

  AST_VEC_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !any_o); // R8
  AST_VEC_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> pend_i[idx_o]); // R8
  AST_VEC_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> ((pend_i & ((N_IN'(1) << idx_o) - N_IN'(1))) == '0)); // R8
endmodule

// File: rtl/irqc_regs.sv
module irqc_regs
  import irqc_pkg::*;
#(
  parameter int N_IN   = 32,
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_IN-1:0]   status_i,
  input  logic [N_IN-1:0]   pend_i,
  input  logic [IDX_W-1:0]  vec_idx_i,
  input  logic              vec_any_i,
  output logic [N_IN-1:0]   enable_o,
  output logic [N_IN-1:0]   ack_o,
  output logic              me_o,
  output logic              hie_o,
  output logic [DATA_W-1:0] rdata_o
);
  logic              hi_zero;
  reg_sel_e          sel;
  logic              wr_hit;
  logic              rd_hit;
  logic [N_IN-1:0]   wbits;
  logic [N_IN-1:0]   en_q;
  logic [N_IN-1:0]   en_d;
  logic              en_ce;
  logic [1:0]        mst_q;
  logic [1:0]        mst_d;
  logic              mst_ce;
  logic [DATA_W-1:0] rdata_q;
  logic [DATA_W-1:0] rdata_d;
  logic              rdata_ce;
  logic              set_we;
  logic              clr_we;

  if (ADDR_W > 5) begin : g_hi_dec
    assign hi_zero = ~|addr_i[ADDR_W-1:5];
  end else begin : g_no_hi
    assign hi_zero = 1'b1;
  end

  function automatic logic [DATA_W-1:0] widen(input logic [N_IN-1:0] v);
    logic [DATA_W-1:0] w;
    w = '0;
    w[N_IN-1:0] = v;
    return w;
  endfunction

  always_comb begin
    sel    = reg_sel_e'(addr_i[4:2]);
    wr_hit = wr_i & hi_zero;
    rd_hit = rd_i & hi_zero;
    wbits  = wdata_i[N_IN-1:0];
    set_we = wr_hit && (sel == REG_SETEN);
    clr_we = wr_hit && (sel == REG_CLREN);
    ack_o  = (wr_hit && (sel == REG_ACK)) ? wbits : '0;
  end

  always_comb begin
    en_d  = en_q;
    en_ce = 1'b0;
    if (wr_hit) begin
      unique case (sel)
        REG_EN:    begin en_d = wbits;          en_ce = 1'b1; end
        REG_SETEN: begin en_d = en_q | wbits;   en_ce = 1'b1; end
        REG_CLREN: begin en_d = en_q & ~wbits;  en_ce = 1'b1; end
        default:   begin en_d = en_q;           en_ce = 1'b0; end
      endcase
    end
  end

  always_comb begin
    mst_d  = wdata_i[1:0];
    mst_ce = wr_hit && (sel == REG_MASTER);
  end

  always_comb begin
    rdata_ce = rd_i;
    rdata_d  = '0;
    if (rd_hit) begin
      unique case (sel)
        REG_STAT:   rdata_d = widen(status_i);
        REG_PEND:   rdata_d = widen(pend_i);
        REG_EN:     rdata_d = widen(en_q);
        REG_VEC:    rdata_d = vec_any_i ? DATA_W'(vec_idx_i) : '1;
        REG_MASTER: rdata_d = {{(DATA_W-2){1'b0}}, mst_q};
        default:    rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= '0;
      mst_q   <= 2'b00;
      rdata_q <= '0;
    end else begin
      if (en_ce)    en_q    <= en_d;
      if (mst_ce)   mst_q   <= mst_d;
      if (rdata_ce) rdata_q <= rdata_d;
    end
  end

  assign enable_o = en_q;
  assign me_o     = mst_q[0];
  assign hie_o    = mst_q[1];
  assign rdata_o  = rdata_q;

  AST_SET_EN: assert property (@(posedge clk) disable iff (!rst_n)
    set_we |=> ((en_q & $past(wbits)) == $past(wbits))); // R5
  AST_CLR_EN: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((en_q & $past(wbits)) == '0)); // R5
  AST_MASTER_WR: assert property (@(posedge clk) disable iff (!rst_n)
    mst_ce |=> ({hie_o, me_o} == $past(wdata_i[1:0]))); // R7
  AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_i |=> $stable(rdata_o)); // R9
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int          N_IN      = 32,
  parameter int          ADDR_W    = 8,
  parameter logic [31:0] EDGE_MASK = 32'h0000_0000
) (
  input  logic              clk,
  input  logic              rst_n_i,
  input  logic [N_IN-1:0]   irq_lines_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              irq_o
);
  localparam int IDX_W = (N_IN > 1) ? $clog2(N_IN) : 1;

  logic              rst_n;
  logic [N_IN-1:0]   status;
  logic [N_IN-1:0]   enable;
  logic [N_IN-1:0]   ack;
  logic [N_IN-1:0]   pend;
  logic [IDX_W-1:0]  vec_idx;
  logic              vec_any;
  logic              me;
  logic              hie;

  irqc_rst_sync u_rst (
    .clk      (clk),
    .arst_n_i (rst_n_i),
    .rst_n_o  (rst_n)
  );

  irqc_capture #(.N_IN(N_IN), .EDGE_CFG(EDGE_MASK)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .line_i   (irq_lines_i),
    .ack_i    (ack),
    .status_o (status)
  );

  assign pend = status & enable;

  irqc_prio #(.N_IN(N_IN), .IDX_W(IDX_W)) u_prio (
    .clk    (clk),
    .rst_n  (rst_n),
    .pend_i (pend),
    .idx_o  (vec_idx),
    .any_o  (vec_any)
  );

  irqc_regs #(.N_IN(N_IN), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (bus_wr_i),
    .rd_i      (bus_rd_i),
    .addr_i    (bus_addr_i),
    .wdata_i   (bus_wdata_i),
    .status_i  (status),
    .pend_i    (pend),
    .vec_idx_i (vec_idx),
    .vec_any_i (vec_any),
    .enable_o  (enable),
    .ack_o     (ack),
    .me_o      (me),
    .hie_o     (hie),
    .rdata_o   (bus_rdata_o)
  );

  assign irq_o = vec_any & me & hie;

  AST_IRQ_NEEDS_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (me && hie)); // R7
  AST_IRQ_ENABLED_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((status & enable) != '0)); // R6
  AST_ENABLE_ZERO_MASKS: assert property (@(posedge clk) disable iff (!rst_n)
    (enable == '0) |-> !irq_o); // R4
endmodule

// File: tb/irqc_top_tb.sv
module irqc_top_tb;
  localparam int          N      = 12;
  localparam int          AW     = 8;
  localparam logic [31:0] EMASK  = 32'h0000_0A5C;
  localparam logic [N-1:0] EDGE  = EMASK[N-1:0];

  logic          clk;
  logic          rst_n;
  logic [N-1:0]  lines;
  logic          wr;
  logic          rd;
  logic [AW-1:0] addr;
  logic [31:0]   wdata;
  logic [31:0]   rdata;
  logic          irq;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  logic [N-1:0] m_stat;
  logic [N-1:0] m_en;
  logic [N-1:0] m_prev;
  logic [1:0]   m_mst;

  irqc_top #(.N_IN(N), .ADDR_W(AW), .EDGE_MASK(EMASK)) u_dut (
    .clk         (clk),
    .rst_n_i     (rst_n),
    .irq_lines_i (lines),
    .bus_wr_i    (wr),
    .bus_rd_i    (rd),
    .bus_addr_i  (addr),
    .bus_wdata_i (wdata),
    .bus_rdata_o (rdata),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [31:0] model_read(input logic [AW-1:0] a);
    logic [N-1:0] p;
    logic [31:0]  v;
    p = m_stat & m_en;
    v = '0;
    if (a[AW-1:5] != '0) return '0;
    case (a[4:2])
      3'd0: v[N-1:0] = m_stat;
      3'd1: v[N-1:0] = p;
      3'd2: v[N-1:0] = m_en;
      3'd6: begin
        v = 32'hFFFF_FFFF;
        for (int i = N - 1; i >= 0; i--) if (p[i]) v = i;
      end
      3'd7: v[1:0] = m_mst;
      default: v = '0;
    endcase
    return v;
  endfunction

  function automatic string read_tag(input logic [AW-1:0] a);
    if (a[AW-1:5] != '0) return "R9";
    case (a[4:2])
      3'd0: return "R1";
      3'd1: return "R6";
      3'd2: return "R5";
      3'd6: return "R8";
      3'd7: return "R7";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] ln, input logic w, input logic r,
                      input logic [AW-1:0] a, input logic [31:0] d, input bit chk);
    logic [31:0]  exp_rd;
    logic [N-1:0] setv;
    logic [N-1:0] ackv;
    logic         hit;
    logic         exp_irq;
    @(negedge clk);
    lines = ln; wr = w; rd = r; addr = a; wdata = d;
    exp_rd = model_read(a);
    @(posedge clk);
    hit  = (a[AW-1:5] == '0);
    setv = (ln & ~m_prev & EDGE) | (ln & ~EDGE);
    ackv = (w && hit && a[4:2] == 3'd3) ? d[N-1:0] : '0;
    m_stat = (m_stat & ~ackv) | setv;
    m_prev = ln;
    if (w && hit) begin
      case (a[4:2])
        3'd2: m_en = d[N-1:0];
        3'd4: m_en = m_en | d[N-1:0];
        3'd5: m_en = m_en & ~d[N-1:0];
        3'd7: m_mst = d[1:0];
        default: ;
      endcase
    end
    @(negedge clk);
    wr = 1'b0; rd = 1'b0;
    exp_irq = ((m_stat & m_en) != '0) && (m_mst == 2'b11);
    if (chk) begin
      check(irq == exp_irq, "R7", {31'b0, irq}, {31'b0, exp_irq});
      if (r) check(rdata == exp_rd, read_tag(a), rdata, exp_rd);
    end
  endtask

  task automatic wr_reg(input logic [N-1:0] ln, input logic [AW-1:0] a, input logic [31:0] d);
    step(ln, 1'b1, 1'b0, a, d, 1'b1);
  endtask

  task automatic rd_lit(input logic [N-1:0] ln, input logic [AW-1:0] a,
                        input logic [31:0] exp, input string req);
    step(ln, 1'b0, 1'b1, a, 32'h0, 1'b1);
    check(rdata == exp, req, rdata, exp);
  endtask

  task automatic irq_lit(input logic exp, input string req);
    check(irq == exp, req, {31'b0, irq}, {31'b0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=0x%08h expected=0x%08h", 32'd0, 32'd1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; lines = '0; wr = 1'b0; rd = 1'b0; addr = '0; wdata = '0;
    m_stat = '0; m_en = '0; m_prev = '0; m_mst = 2'b00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) step('0, 1'b0, 1'b0, '0, '0, 1'b0);

    // R11 reset state
    irq_lit(1'b0, "R11");
    rd_lit('0, 8'h00, 32'h0, "R11");
    rd_lit('0, 8'h18, 32'hFFFF_FFFF, "R11");
    rd_lit('0, 8'h1C, 32'h0, "R11");

    // R10 upper bits ignored
    wr_reg('0, 8'h08, 32'hFFFF_FFFF);
    rd_lit('0, 8'h08, 32'h0000_0FFF, "R10");
    wr_reg('0, 8'h1C, 32'h0000_0003);
    rd_lit('0, 8'h1C, 32'h0000_0003, "R7");

    // R1 edge line 3 pulse: sticky after line drops
    step(12'h008, 1'b0, 1'b0, '0, '0, 1'b1);
    irq_lit(1'b1, "R1");
    step(12'h000, 1'b0, 1'b0, '0, '0, 1'b1);
    rd_lit('0, 8'h00, 32'h0000_0008, "R1");
    rd_lit('0, 8'h18, 32'h0000_0003, "R8");
    // held high edge line does not retrigger after ack
    step(12'h008, 1'b0, 1'b0, '0, '0, 1'b1);
    wr_reg(12'h008, 8'h0C, 32'h0000_0008);
    rd_lit(12'h008, 8'h00, 32'h0, "R1");
    step('0, 1'b0, 1'b0, '0, '0, 1'b1);

    // R2 level line 1 held high, ack does not clear
    step(12'h002, 1'b0, 1'b0, '0, '0, 1'b1);
    wr_reg(12'h002, 8'h0C, 32'hFFFF_FFFF);
    rd_lit(12'h002, 8'h00, 32'h0000_0002, "R2");
    wr_reg(12'h000, 8'h0C, 32'h0000_0002);
    rd_lit(12'h000, 8'h00, 32'h0, "R3");
    irq_lit(1'b0, "R3");

    // R8 priority lowest of several
    step(12'h850, 1'b0, 1'b0, '0, '0, 1'b1);
    rd_lit('0, 8'h18, 32'h0000_0004, "R8");
    // R4 enable cleared: status kept, no request
    wr_reg('0, 8'h08, 32'h0);
    irq_lit(1'b0, "R4");
    rd_lit('0, 8'h00, 32'h0000_0850, "R4");
    rd_lit('0, 8'h04, 32'h0, "R6");
    rd_lit('0, 8'h18, 32'hFFFF_FFFF, "R8");
    // R5 set/clear
    wr_reg('0, 8'h10, 32'h0000_0840);
    wr_reg('0, 8'h14, 32'h0000_0040);
    rd_lit('0, 8'h08, 32'h0000_0800, "R5");
    rd_lit('0, 8'h18, 32'h0000_000B, "R8");
    // R7 one master bit off
    wr_reg('0, 8'h1C, 32'h0000_0001);
    irq_lit(1'b0, "R7");
    wr_reg('0, 8'h1C, 32'h0000_0003);
    irq_lit(1'b1, "R7");
    // R9 read-only and unmapped
    wr_reg('0, 8'h00, 32'h0);
    wr_reg('0, 8'h18, 32'h0);
    rd_lit('0, 8'h00, 32'h0000_0850, "R9");
    rd_lit('0, 8'h0C, 32'h0, "R9");
    rd_lit('0, 8'h10, 32'h0, "R9");
    wr_reg('0, 8'h28, 32'hFFFF_FFFF);
    rd_lit('0, 8'h28, 32'h0, "R9");
    rd_lit('0, 8'h08, 32'h0000_0800, "R9");
    // R3 ack racing a new edge: set wins
    wr_reg(12'h010, 8'h0C, 32'h0000_0010);
    rd_lit('0, 8'h00, 32'h0000_0850, "R3");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [N-1:0]  ln;
      logic [AW-1:0] a;
      logic [31:0]   d;
      int            op;
      ln = N'($urandom) & N'($urandom);
      a  = {2'b00, 4'($urandom % 16), 2'b00};
      d  = $urandom;
      op = $urandom % 10;
      if (a[4:2] == 3'd7 && ($urandom % 4) != 0) d = 32'h3;
      if (op < 4)      step(ln, 1'b0, 1'b0, a, d, 1'b1);
      else if (op < 7) step(ln, 1'b0, 1'b1, a, d, 1'b1);
      else             step(ln, 1'b1, 1'b0, a, d, 1'b1);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule